// File: doc/BRIEF.md
# Key-Gated EEPROM Erase Controller

This block erases words of a small on-chip data EEPROM under software control. Software picks the erase size and the target word, writes a two-byte unlock key to a dedicated key register, then sets the start bit together with the write-enable bit. The controller accepts the start only when it comes within a short window after the key. It then drives the array's erase port for a programmable number of clock cycles per word. It steps through one word, an aligned group of four or eight words, or the whole array.

The start bit reads back as a busy indication for polling, and it clears by itself when the last word is done. At that same moment a sticky completion flag is set. The interrupt output follows that flag when the interrupt is enabled. While an erase runs, the size, enable and address registers are frozen, so an operation in flight cannot be altered.

Top module: `eeprom_erase_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, `ee_erase` is low and `irq` is low.
- R2: A start is honoured only after this key sequence. Two key-register writes (address 4) carry byte 0x55 and then 0xAA on the next cycle. A control write (address 0) with bit 15 (start) and bit 14 (write-enable) both set must then follow, in the first or the second cycle after the 0xAA write.
- R3: A start after a key sequence that is broken, out of order or not on consecutive cycles, or a start that arrives later than the window, is ignored: no word is erased, and the start bit reads 0.
- R4: A start with bit 14 clear launches nothing, even after a valid key.
- R5: Bits [1:0] of the start write select the size: 00 erases the one word at {page, offset}; 01 erases four words from that address rounded down to a multiple of 4; 10 erases eight words from the address rounded down to a multiple of 8; 11 erases every word from 0 to the top.
- R6: Each word is erased with `ee_erase` high and `ee_addr` held for ERASE_CYC consecutive cycles. Addresses ascend with no gap. The start bit (control bit 15) reads 1 for the whole operation.
- R7: At the clock edge that ends the last word, the start bit clears and the done flag (status bit 0) sets. `irq` is registered: it is high exactly one cycle after done flag AND interrupt enable (status bit 1) is true.
- R8: The done flag is cleared only by writing 0 to status bit 0; writing 1 there leaves it unchanged.
- R9: While an erase runs, writes to the control, page (address 2) and offset (address 3) registers are ignored.
- R10: `bus_rdata` returns the register selected by `bus_addr` one cycle later. Control reads {start, write-enable, 12 zeros, size}, status reads {14 zeros, enable, flag}, page and offset read zero-extended, and the key register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ee_erase | output | 1 | Erase strobe to the array |
| ee_addr | output | PAGE_W+OFS_W | Word being erased |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong unlock state shows up at once as an erase strobe that starts, or fails to start, on the cycle after the control write. It also shows in the start bit read back one cycle later. A miscounting sequencer gives a wrong address or a strobe of the wrong length on the very first cycle it goes astray, because the strobe and the address are compared against a reference on every clock. A faulty flag or enable register shows up as a wrong `irq` one cycle later and in the next status read.

// File: rtl/ee_erase_pkg.sv
package ee_erase_pkg;
  typedef enum logic [1:0] {
    SZ_ONE   = 2'b00,
    SZ_FOUR  = 2'b01,
    SZ_EIGHT = 2'b10,
    SZ_ALL   = 2'b11
  } erase_size_e;

  typedef enum logic [1:0] {
    KG_IDLE,
    KG_HALF,
    KG_OPEN1,
    KG_OPEN2
  } key_state_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_PAGE = 3'd2;
  localparam logic [2:0] REG_OFS  = 3'd3;
  localparam logic [2:0] REG_KEY  = 3'd4;

  localparam int CTRL_GO_BIT  = 15;
  localparam int CTRL_WEN_BIT = 14;
  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_IE_BIT   = 1;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/ee_key_gate.sv
module ee_key_gate
  import ee_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       ctrl_wr,
  output logic       armed
);
  key_state_e st_q, st_d;

  // Any key write off-sequence, any idle cycle in the middle of the key, or
  // any control write while open returns the gate to idle.
  always_comb begin
    st_d = KG_IDLE;
    if (key_wr) begin
      if (st_q == KG_HALF && key_byte == KEY_SECOND) st_d = KG_OPEN1;
      else if (key_byte == KEY_FIRST)                st_d = KG_HALF;
    end else if (!ctrl_wr && st_q == KG_OPEN1) begin
      st_d = KG_OPEN2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= KG_IDLE;
    else     st_q <= st_d;
  end

  assign armed = (st_q == KG_OPEN1) || (st_q == KG_OPEN2);
endmodule

// File: rtl/ee_erase_seq.sv
module ee_erase_seq
  import ee_erase_pkg::*;
#(
  parameter int AW        = 8,
  parameter int ERASE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  erase_size_e   size,
  input  logic [AW-1:0] base,
  output logic          busy,
  output logic          erase,
  output logic [AW-1:0] addr,
  output logic          finish
);
  localparam int CW = (ERASE_CYC > 1) ? $clog2(ERASE_CYC) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(ERASE_CYC - 1);
  localparam int LW = AW + 1;

  logic [CW-1:0] cyc_q;
  logic [LW-1:0] left_q;
  logic          busy_q;
  logic [AW-1:0] addr_q;

  logic [AW-1:0] first_addr;
  logic [LW-1:0] first_left;
  logic          word_end;

  always_comb begin
    case (size)
      SZ_ONE: begin
        first_addr = base;
        first_left = '0;
      end
      SZ_FOUR: begin
        first_addr = base & ~AW'(3);
        first_left = LW'(3);
      end
      SZ_EIGHT: begin
        first_addr = base & ~AW'(7);
        first_left = LW'(7);
      end
      default: begin
        first_addr = '0;
        first_left = {1'b0, {AW{1'b1}}};
      end
    endcase
  end

  assign word_end = busy_q && (cyc_q == CYC_LAST);
  assign finish   = word_end && (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
      left_q <= '0;
      addr_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cyc_q  <= '0;
        left_q <= first_left;
        addr_q <= first_addr;
      end
    end else if (word_end) begin
      cyc_q <= '0;
      if (left_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        left_q <= left_q - LW'(1);
        addr_q <= addr_q + AW'(1);
      end
    end else begin
      cyc_q <= cyc_q + CW'(1);
    end
  end

  assign busy  = busy_q;
  assign erase = busy_q;
  assign addr  = addr_q;
endmodule

// File: rtl/eeprom_erase_ctrl.sv
module eeprom_erase_ctrl
  import ee_erase_pkg::*;
#(
  parameter int PAGE_W    = 2,
  parameter int OFS_W     = 6,
  parameter int ERASE_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_we,
  input  logic [2:0]              bus_addr,
  input  logic [15:0]             bus_wdata,
  output logic [15:0]             bus_rdata,
  output logic                    ee_erase,
  output logic [PAGE_W+OFS_W-1:0] ee_addr,
  output logic                    irq
);
  localparam int AW = PAGE_W + OFS_W;

  logic              wen_q;
  erase_size_e       size_q;
  logic              done_flag;
  logic              irq_en;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [15:0]       rdata_q;
  logic              irq_q;

  logic ctrl_wr, stat_wr, page_wr, ofs_wr, key_wr;
  logic armed, busy, finish, start;

  assign ctrl_wr = bus_we && (bus_addr == REG_CTRL);
  assign stat_wr = bus_we && (bus_addr == REG_STAT);
  assign page_wr = bus_we && (bus_addr == REG_PAGE);
  assign ofs_wr  = bus_we && (bus_addr == REG_OFS);
  assign key_wr  = bus_we && (bus_addr == REG_KEY);

  assign start = ctrl_wr && !busy && armed &&
                 bus_wdata[CTRL_GO_BIT] && bus_wdata[CTRL_WEN_BIT];

  ee_key_gate i_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (key_wr),
    .key_byte (bus_wdata[7:0]),
    .ctrl_wr  (ctrl_wr),
    .armed    (armed)
  );

  ee_erase_seq #(
    .AW        (AW),
    .ERASE_CYC (ERASE_CYC)
  ) i_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .size   (erase_size_e'(bus_wdata[1:0])),
    .base   ({page_q, ofs_q}),
    .busy   (busy),
    .erase  (ee_erase),
    .addr   (ee_addr),
    .finish (finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q  <= 1'b0;
      size_q <= SZ_ONE;
      page_q <= '0;
      ofs_q  <= '0;
    end else if (!busy) begin
      if (ctrl_wr) begin
        wen_q  <= bus_wdata[CTRL_WEN_BIT];
        size_q <= erase_size_e'(bus_wdata[1:0]);
      end
      if (page_wr) page_q <= bus_wdata[PAGE_W-1:0];
      if (ofs_wr)  ofs_q  <= bus_wdata[OFS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_flag <= 1'b0;
      irq_en    <= 1'b0;
    end else begin
      if (stat_wr) begin
        irq_en <= bus_wdata[STAT_IE_BIT];
        if (!bus_wdata[STAT_FLAG_BIT]) done_flag <= 1'b0;
      end
      if (finish) done_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= done_flag && irq_en;
      case (bus_addr)
        REG_CTRL: rdata_q <= {busy, wen_q, 12'b0, size_q};
        REG_STAT: rdata_q <= {14'b0, irq_en, done_flag};
        REG_PAGE: rdata_q <= 16'(page_q);
        REG_OFS:  rdata_q <= 16'(ofs_q);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/ee_erase_chk.sv
module ee_erase_chk
  import ee_erase_pkg::*;
#(
  parameter int AW     = 8,
  parameter int PAGE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              ee_erase,
  input logic [AW-1:0]     ee_addr,
  input logic              irq,
  input logic              armed,
  input logic              done_flag,
  input logic              irq_en,
  input logic [PAGE_W-1:0] page_q
);
  a_r2_start_needs_key: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_erase) |-> $past(armed));

  a_r4_start_needs_wen: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_erase) |-> $past(bus_we && bus_addr == REG_CTRL && bus_wdata[CTRL_WEN_BIT]));

  a_r5_addr_steps_up: assert property (@(posedge clk) disable iff (rst)
    (ee_erase && $past(ee_erase)) |->
      (ee_addr == $past(ee_addr) || ee_addr == $past(ee_addr) + AW'(1)));

  a_r7_flag_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_erase) |-> done_flag);

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (done_flag && irq_en) |=> irq);

  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !(done_flag && irq_en) |=> !irq);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !(bus_we && bus_addr == REG_STAT && !bus_wdata[STAT_FLAG_BIT])) |=> done_flag);

  a_r9_page_frozen: assert property (@(posedge clk) disable iff (rst)
    (ee_erase && bus_we && bus_addr == REG_PAGE) |=> $stable(page_q));
endmodule

bind eeprom_erase_ctrl ee_erase_chk #(
  .AW     (PAGE_W + OFS_W),
  .PAGE_W (PAGE_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ee_erase  (ee_erase),
  .ee_addr   (ee_addr),
  .irq       (irq),
  .armed     (armed),
  .done_flag (done_flag),
  .irq_en    (irq_en),
  .page_q    (page_q)
);

// File: tb/test_eeprom_erase_ctrl.sv
module test_eeprom_erase_ctrl;
  localparam int PAGE_W = 2;
  localparam int OFS_W  = 6;
  localparam int ECYC   = 4;
  localparam int AW     = PAGE_W + OFS_W;
  localparam int DEPTH  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic          ee_erase;
  logic [AW-1:0] ee_addr;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eeprom_erase_ctrl #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .ERASE_CYC(ECYC)) i_eeprom_erase_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ee_erase(ee_erase), .ee_addr(ee_addr), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int   q[$];
  bit   m_wen, m_flag, m_ie;
  int   m_size, m_page, m_ofs, m_key;
  logic [15:0] exp_rdata;
  bit   exp_irq;

  function automatic logic [15:0] model_read(input logic [2:0] a, input bit was_busy);
    case (a)
      3'd0: return {was_busy, m_wen, 12'b0, 2'(m_size)};
      3'd1: return {14'b0, m_ie, m_flag};
      3'd2: return 16'(m_page);
      3'd3: return 16'(m_ofs);
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_wen = 0; m_flag = 0; m_ie = 0; m_size = 0; m_page = 0; m_ofs = 0; m_key = 0;
      exp_rdata = '0; exp_irq = 0;
    end else begin
      bit was_busy, fin, armed;
      int nk;
      was_busy = (q.size() > 0);
      exp_rdata = model_read(bus_addr, was_busy);
      exp_irq = m_flag && m_ie;
      armed = (m_key == 2 || m_key == 3);
      fin = 0;
      if (was_busy) begin
        void'(q.pop_front());
        if (q.size() == 0) fin = 1;
      end
      nk = 0;
      if (bus_we && bus_addr == 3'd4) begin
        if (m_key == 1 && bus_wdata[7:0] == 8'hAA) nk = 2;
        else if (bus_wdata[7:0] == 8'h55) nk = 1;
      end else if (m_key == 2 && !(bus_we && bus_addr == 3'd0)) nk = 3;
      if (bus_we && !was_busy) begin
        if (bus_addr == 3'd0) begin
          if (armed && bus_wdata[15] && bus_wdata[14]) begin
            int n, a;
            n = (bus_wdata[1:0] == 2'd0) ? 1 : (bus_wdata[1:0] == 2'd1) ? 4 :
                (bus_wdata[1:0] == 2'd2) ? 8 : DEPTH;
            a = m_page * (1 << OFS_W) + m_ofs;
            a = a - (a % n);
            for (int w = 0; w < n; w++)
              for (int c = 0; c < ECYC; c++) q.push_back(a + w);
          end
          m_wen = bus_wdata[14];
          m_size = int'(bus_wdata[1:0]);
        end
        if (bus_addr == 3'd2) m_page = int'(bus_wdata[PAGE_W-1:0]);
        if (bus_addr == 3'd3) m_ofs = int'(bus_wdata[OFS_W-1:0]);
      end
      if (bus_we && bus_addr == 3'd1) begin
        m_ie = bus_wdata[1];
        if (!bus_wdata[0]) m_flag = 0;
      end
      if (fin) m_flag = 1;
      m_key = nk;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit e;
      e = (q.size() > 0);
      chk(ee_erase == e, "R6", "ee_erase", ee_erase, e);
      if (e) chk(ee_addr == AW'(q[0]), "R5", "ee_addr", ee_addr, q[0]);
      chk(irq == exp_irq, "R7", "irq", irq, exp_irq);
      chk(bus_rdata == exp_rdata, "R10", "bus_rdata", bus_rdata, exp_rdata);
    end
  end

  // operation observers
  int erase_cycles;
  int first_addr;
  bit seen;
  always @(posedge clk) begin
    if (ee_erase) begin
      erase_cycles++;
      if (!seen) begin first_addr = int'(ee_addr); seen = 1; end
    end
  end

  task automatic mark();
    erase_cycles = 0; seen = 0; first_addr = -1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    chk(bus_rdata == exp, tag, "read", bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic key();
    wr(3'd4, 16'h0055);
    wr(3'd4, 16'h00AA);
  endtask

  task automatic wait_done();
    while (ee_erase) @(negedge clk);
    idle(1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected <150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset values
    rd_chk(3'd0, 16'h0, "R1");
    rd_chk(3'd1, 16'h0, "R1");
    rd_chk(3'd2, 16'h0, "R1");
    rd_chk(3'd3, 16'h0, "R1");
    chk(ee_erase == 1'b0, "R1", "ee_erase", ee_erase, 0);
    chk(irq == 1'b0, "R1", "irq", irq, 0);

    // R10 register map
    wr(3'd2, 16'h0001);
    wr(3'd3, 16'h0005);
    wr(3'd0, 16'h4000);
    wr(3'd1, 16'h0002);
    rd_chk(3'd2, 16'h0001, "R10");
    rd_chk(3'd3, 16'h0005, "R10");
    rd_chk(3'd0, 16'h4000, "R10");
    rd_chk(3'd4, 16'h0000, "R10");

    // R2 single word, start in the first window cycle
    mark();
    key();
    wr(3'd0, 16'hC000);
    chk(ee_erase == 1'b1, "R2", "started", ee_erase, 1);
    rd_chk(3'd0, 16'hC000, "R6");
    wait_done();
    chk(erase_cycles == ECYC, "R6", "cycles one", erase_cycles, ECYC);
    chk(first_addr == 'h45, "R5", "addr one", first_addr, 'h45);
    rd_chk(3'd1, 16'h0003, "R7");
    chk(irq == 1'b1, "R7", "irq", irq, 1);
    rd_chk(3'd0, 16'h4000, "R7");

    // R8 flag clear rules
    wr(3'd1, 16'h0003);
    rd_chk(3'd1, 16'h0003, "R8");
    wr(3'd1, 16'h0002);
    rd_chk(3'd1, 16'h0002, "R8");
    chk(irq == 1'b0, "R8", "irq", irq, 0);

    // R5 four words, start in second window cycle
    wr(3'd3, 16'h000E);
    mark();
    key();
    idle(1);
    wr(3'd0, 16'hC001);
    chk(ee_erase == 1'b1, "R2", "second window", ee_erase, 1);
    wait_done();
    chk(erase_cycles == 4 * ECYC, "R5", "cycles four", erase_cycles, 4 * ECYC);
    chk(first_addr == 'h4C, "R5", "addr four", first_addr, 'h4C);

    // R3 late start
    mark();
    key();
    idle(2);
    wr(3'd0, 16'hC000);
    idle(2);
    chk(erase_cycles == 0, "R3", "late start", erase_cycles, 0);
    rd_chk(3'd0, 16'h4000, "R3");
    // R3 gap inside key
    wr(3'd4, 16'h0055); idle(1); wr(3'd4, 16'h00AA);
    wr(3'd0, 16'hC000);
    // R3 wrong byte in the middle
    wr(3'd4, 16'h0055); wr(3'd4, 16'h0012); wr(3'd4, 16'h00AA);
    wr(3'd0, 16'hC000);
    // R3 reversed order
    wr(3'd4, 16'h00AA); wr(3'd4, 16'h0055);
    wr(3'd0, 16'hC000);
    idle(2);
    chk(erase_cycles == 0, "R3", "broken keys", erase_cycles, 0);

    // R4 write-enable clear
    key();
    wr(3'd0, 16'h8000);
    idle(2);
    chk(erase_cycles == 0, "R4", "no wen", erase_cycles, 0);
    rd_chk(3'd0, 16'h0000, "R4");

    // R9 eight words with writes during the run
    wr(3'd2, 16'h0002);
    wr(3'd3, 16'h0013);
    mark();
    key();
    wr(3'd0, 16'hC002);
    wr(3'd2, 16'h0003);
    wr(3'd3, 16'h0001);
    wr(3'd0, 16'h4003);
    rd_chk(3'd2, 16'h0002, "R9");
    rd_chk(3'd3, 16'h0013, "R9");
    rd_chk(3'd0, 16'hC002, "R9");
    wait_done();
    chk(erase_cycles == 8 * ECYC, "R5", "cycles eight", erase_cycles, 8 * ECYC);
    chk(first_addr == 'h90, "R5", "addr eight", first_addr, 'h90);

    // R5 full array
    wr(3'd1, 16'h0002);
    mark();
    key();
    wr(3'd0, 16'hC003);
    wait_done();
    chk(erase_cycles == DEPTH * ECYC, "R5", "cycles all", erase_cycles, DEPTH * ECYC);
    chk(first_addr == 0, "R5", "addr all", first_addr, 0);
    rd_chk(3'd1, 16'h0003, "R7");
    chk(irq == 1'b1, "R7", "irq all", irq, 1);

    idle(2);
    finish_run();
  end
endmodule